// File: doc/BRIEF.md
# Edge-Triggered Interrupt Line Controller

This block watches up to forty synchronous interrupt lines and turns chosen transitions on them into sticky pending flags plus a one-clock pulse on a per-line output. Software programs it through a small 32-bit register port. For each line it can set an interrupt enable (mask), an event enable, a rising-edge select, a falling-edge select and a software trigger. A pending flag is cleared by writing one to it.

The lines are split across two register banks. Bank 0 holds lines 0 to 31. Bank 1 holds lines 32 to 39, where line n sits at bit n-32. A fixed set of lines is hard-wired as direct lines. Their enables come out of reset set, and their edge-select, trigger and pending bits cannot be written. Because of this, a direct line never produces a pending flag or a pulse.

The register port takes a single-cycle strobe. A write takes effect at the strobe edge. Read data appears on the output one cycle after the read strobe and holds until the next read.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, the enable register reads 0xFF820000 in bank 0 and 0x00000087 in bank 1. Every other register reads zero and no output pulses.
- R2: The byte offsets are: enable 0x00, event enable 0x04, rising select 0x08, falling select 0x0C, software trigger 0x10, pending 0x14. Bank 1 uses the same offsets plus 0x20. Read data is registered: it shows the addressed register in the cycle after the strobe.
- R3: A write to either enable register keeps only the bits that exist in that bank. Bank 1 reads back bits 31:8 as zero.
- R4: Writes to rising select, falling select, software trigger and pending are ignored on direct bits (bank 0 mask 0xFF820000, bank 1 mask 0x00000087).
- R5: A low-to-high change on an enabled line with rising select set raises its pending bit. It also drives its output bit high for exactly the one cycle after the clock edge that sees the change.
- R6: A high-to-low change on an enabled line with falling select set does the same. With the select for that direction clear, the change has no effect.
- R7: While a line is masked, its changes raise no pending bit and no pulse, but its level is still tracked. Unmasking it later produces no event unless the level changes again.
- R8: A software-trigger write raises pending and pulses once only for bits that go from 0 to 1 in the trigger register, are enabled, and are not already pending. The written value is stored either way.
- R9: Writing 1 to a pending bit clears it and the matching trigger bit. Writing 0 leaves both unchanged.
- R10: If a qualifying edge and a clear of the same pending bit fall in the same cycle, the bit stays set and the line pulses.
- R11: Reads of unmapped or unaligned offsets (0x18, 0x1C, 0x38, 0x3C, 0x40 and above, nonzero low two bits) return zero. Writes to them change nothing.
- R12: Direct lines never raise a pending bit or pulse, whether from their input or from a trigger write.
- R13: The read data output holds its value in every cycle that has no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 40 | Interrupt line levels, already synchronous |
| reg_valid_i | input | 1 | Register access strobe, one cycle |
| reg_write_i | input | 1 | 1 = write, 0 = read, qualified by the strobe |
| reg_addr_i | input | 8 | Byte offset of the access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_pulse_o | output | 40 | One-cycle event pulse per line |

## Verification
Every result lands exactly one clock edge after its cause:
- A line change driven before edge k shows on the pulse output just after edge k.
- A write strobed at edge k updates the registers and any trigger pulse at edge k.
- A read strobed at edge k delivers its data just after edge k.

The bench drives all inputs on falling edges and samples one falling edge later. Each pulse is therefore caught in its single valid cycle, and one directed case confirms that the pulse has dropped one edge later. Read-hold behaviour is checked by sampling read data across idle cycles and across a write that changes the register last read.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int unsigned DATA_W      = 32;
    localparam int unsigned STRIDE_LOG2 = 5;   // 0x20 bytes per bank

    typedef enum logic [2:0] {
        SEL_IMASK  = 3'd0,
        SEL_EMASK  = 3'd1,
        SEL_RISE   = 3'd2,
        SEL_FALL   = 3'd3,
        SEL_SWTRIG = 3'd4,
        SEL_PEND   = 3'd5,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } port_state_t;

endpackage

// File: rtl/ext_irq_decode.sv
module ext_irq_decode
    import ext_irq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NUM_BANKS = 2,
    localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [BANK_W-1:0] bank_o,
    output reg_sel_e          sel_o
);

    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_BANKS << STRIDE_LOG2);

    always_comb begin
        hit_o  = (addr_i[1:0] == 2'b00) && (addr_i < SPAN) && (addr_i[4:2] <= 3'd5);
        bank_o = BANK_W'(addr_i >> STRIDE_LOG2);
        sel_o  = hit_o ? reg_sel_e'(addr_i[4:2]) : SEL_NONE;
    end

endmodule

// File: rtl/ext_irq_bank.sv
module ext_irq_bank
    import ext_irq_pkg::*;
#(
    parameter int unsigned       WIDTH  = 32,
    parameter logic [WIDTH-1:0]  DIRECT = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WIDTH-1:0]  line_i,
    input  logic              wr_en_i,
    input  reg_sel_e          sel_i,
    input  logic [WIDTH-1:0]  wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [WIDTH-1:0]  pulse_o
);

    localparam logic [WIDTH-1:0] CFG = ~DIRECT;

    typedef struct packed {
        logic [WIDTH-1:0] imask;
        logic [WIDTH-1:0] emask;
        logic [WIDTH-1:0] rise;
        logic [WIDTH-1:0] fall;
        logic [WIDTH-1:0] swtrig;
        logic [WIDTH-1:0] pend;
        logic [WIDTH-1:0] level;
        logic [WIDTH-1:0] pulse;
    } bank_state_t;

    localparam bank_state_t RESET_VAL = '{imask: DIRECT, default: '0};

    bank_state_t      state_d, state_q;
    logic [WIDTH-1:0] edge_hit;
    logic [WIDTH-1:0] sw_hit;
    logic [WIDTH-1:0] clr_bits;

    always_comb begin
        state_d  = state_q;
        sw_hit   = '0;
        clr_bits = '0;
        // qualified hardware edge against the stored previous level
        edge_hit = (line_i ^ state_q.level) & state_q.imask
                 & ((line_i & state_q.rise) | (~line_i & state_q.fall));
        state_d.level = line_i;

        if (wr_en_i) begin
            unique case (sel_i)
                SEL_IMASK: state_d.imask = wdata_i;
                SEL_EMASK: state_d.emask = wdata_i;
                SEL_RISE:  state_d.rise  = wdata_i & CFG;
                SEL_FALL:  state_d.fall  = wdata_i & CFG;
                SEL_SWTRIG: begin
                    sw_hit = (wdata_i & CFG) & ~state_q.swtrig & state_q.imask & ~state_q.pend;
                    state_d.swtrig = wdata_i & CFG;
                end
                SEL_PEND: begin
                    clr_bits = state_q.pend & wdata_i & CFG;
                    state_d.swtrig = state_q.swtrig & ~clr_bits;
                end
                default: ;
            endcase
        end

        // a fresh edge outranks a same-cycle clear
        state_d.pend  = (state_q.pend & ~clr_bits) | sw_hit | edge_hit;
        state_d.pulse = sw_hit | edge_hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= RESET_VAL;
        else         state_q <= state_d;
    end

    always_comb begin
        unique case (sel_i)
            SEL_IMASK:  rdata_o = DATA_W'(state_q.imask);
            SEL_EMASK:  rdata_o = DATA_W'(state_q.emask);
            SEL_RISE:   rdata_o = DATA_W'(state_q.rise);
            SEL_FALL:   rdata_o = DATA_W'(state_q.fall);
            SEL_SWTRIG: rdata_o = DATA_W'(state_q.swtrig);
            SEL_PEND:   rdata_o = DATA_W'(state_q.pend);
            default:    rdata_o = '0;
        endcase
    end

    assign pulse_o = state_q.pulse;

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int unsigned BANK0_LINES = 32,
    parameter int unsigned BANK1_LINES = 8,
    parameter logic [31:0] DIRECT0     = 32'hFF82_0000,
    parameter logic [31:0] DIRECT1     = 32'h0000_0087,
    parameter int unsigned ADDR_W      = 8,
    localparam int unsigned NUM_LINES  = BANK0_LINES + BANK1_LINES
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_LINES-1:0] line_i,
    input  logic                 reg_valid_i,
    input  logic                 reg_write_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [31:0]          reg_wdata_i,
    output logic [31:0]          reg_rdata_o,
    output logic [NUM_LINES-1:0] irq_pulse_o
);

    localparam int unsigned NUM_BANKS = 2;
    localparam int unsigned BANK_W    = 1;
    localparam logic [NUM_LINES-1:0] DIRECT_LINES =
        {DIRECT1[BANK1_LINES-1:0], DIRECT0[BANK0_LINES-1:0]};

    logic              acc_hit;
    logic [BANK_W-1:0] acc_bank;
    reg_sel_e          acc_sel;
    logic [31:0]       bank_rdata [NUM_BANKS];
    port_state_t       port_d, port_q;

    ext_irq_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_decode (
        .addr_i (reg_addr_i),
        .hit_o  (acc_hit),
        .bank_o (acc_bank),
        .sel_o  (acc_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int unsigned W    = (b == 0) ? BANK0_LINES : BANK1_LINES;
        localparam int unsigned BASE = (b == 0) ? 0 : BANK0_LINES;
        localparam logic [31:0] DM   = (b == 0) ? DIRECT0 : DIRECT1;

        logic         wr_en;
        logic [W-1:0] pulse;

        assign wr_en = reg_valid_i & reg_write_i & acc_hit & (acc_bank == BANK_W'(b));

        ext_irq_bank #(
            .WIDTH  (W),
            .DIRECT (DM[W-1:0])
        ) u_bank (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .line_i  (line_i[BASE +: W]),
            .wr_en_i (wr_en),
            .sel_i   (acc_sel),
            .wdata_i (reg_wdata_i[W-1:0]),
            .rdata_o (bank_rdata[b]),
            .pulse_o (pulse)
        );

        assign irq_pulse_o[BASE +: W] = pulse;
    end

    always_comb begin
        port_d = port_q;
        if (reg_valid_i && !reg_write_i) begin
            port_d.rdata = acc_hit ? bank_rdata[acc_bank] : '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) port_q <= '0;
        else         port_q <= port_d;
    end

    assign reg_rdata_o = port_q.rdata;

endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk #(
    parameter int unsigned          NUM_LINES    = 40,
    parameter int unsigned          ADDR_W       = 8,
    parameter logic [NUM_LINES-1:0] DIRECT_LINES = '0
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NUM_LINES-1:0] line_i,
    input logic                 reg_valid_i,
    input logic                 reg_write_i,
    input logic [ADDR_W-1:0]    reg_addr_i,
    input logic [31:0]          reg_rdata_o,
    input logic [NUM_LINES-1:0] irq_pulse_o
);

    logic read_unmapped;
    assign read_unmapped = (reg_addr_i[1:0] != 2'b00) || (reg_addr_i >= ADDR_W'(64))
                         || (reg_addr_i[4:2] > 3'd5);

    p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (irq_pulse_o == '0) && (reg_rdata_o == '0));

    // R5 and R8: a pulse needs a level change or a write one edge earlier
    p_pulse_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_pulse_o != '0) |->
            (($past(line_i) != $past(line_i, 2)) || $past(reg_valid_i && reg_write_i)));

    p_unmapped_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(reg_valid_i && !reg_write_i && read_unmapped) |-> (reg_rdata_o == '0));

    p_direct_silent_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_pulse_o & DIRECT_LINES) == '0);

    p_rdata_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(reg_valid_i && !reg_write_i) |-> $stable(reg_rdata_o));

endmodule

bind edge_irq_ctrl ext_irq_chk #(
    .NUM_LINES    (NUM_LINES),
    .ADDR_W       (ADDR_W),
    .DIRECT_LINES (DIRECT_LINES)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_i      (line_i),
    .reg_valid_i (reg_valid_i),
    .reg_write_i (reg_write_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_pulse_o (irq_pulse_o)
);

// File: tb/tb_edge_irq_ctrl.sv
`timescale 1ns/1ps
module tb_edge_irq_ctrl;

    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_LN = 2'd2;

    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  addr;
        logic [39:0] data;
        logic [39:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 66;
    // WR: write data, expect pulse; RD: expect read data; LN: drive lines, expect pulse
    localparam vec_t VECS [NV] = '{
        '{K_RD, 8'h00, 40'h0, 40'hFF820000, 4'd1},          // R1
        '{K_RD, 8'h20, 40'h0, 40'h87, 4'd2},                // R1 / R2 bank 1 enable
        '{K_RD, 8'h14, 40'h0, 40'h0, 4'd1},
        '{K_RD, 8'h08, 40'h0, 40'h0, 4'd1},
        '{K_WR, 8'h00, 40'hFFFFFFFF, 40'h0, 4'd3},          // R3
        '{K_RD, 8'h00, 40'h0, 40'hFFFFFFFF, 4'd3},
        '{K_WR, 8'h20, 40'hFFFFFFFF, 40'h0, 4'd3},
        '{K_RD, 8'h20, 40'h0, 40'hFF, 4'd3},
        '{K_WR, 8'h24, 40'hFFFFFFFF, 40'h0, 4'd3},
        '{K_RD, 8'h24, 40'h0, 40'hFF, 4'd3},
        '{K_WR, 8'h08, 40'hFFFFFFFF, 40'h0, 4'd4},          // R4
        '{K_RD, 8'h08, 40'h0, 40'h007DFFFF, 4'd4},
        '{K_WR, 8'h2C, 40'hFFFFFFFF, 40'h0, 4'd4},
        '{K_RD, 8'h2C, 40'h0, 40'h78, 4'd4},
        '{K_LN, 8'h00, 40'h8, 40'h8, 4'd5},                 // R5 rising line 3
        '{K_RD, 8'h14, 40'h0, 40'h8, 4'd5},
        '{K_LN, 8'h00, 40'h0, 40'h0, 4'd6},                 // R6 fall disabled bank 0
        '{K_LN, 8'h00, 40'h0800000000, 40'h0, 4'd5},        // rise disabled bank 1
        '{K_LN, 8'h00, 40'h0, 40'h0800000000, 4'd6},        // R6 falling line 35
        '{K_RD, 8'h34, 40'h0, 40'h8, 4'd2},
        '{K_WR, 8'h14, 40'h0, 40'h0, 4'd9},                 // R9 zero write
        '{K_RD, 8'h14, 40'h0, 40'h8, 4'd9},
        '{K_WR, 8'h14, 40'h8, 40'h0, 4'd9},
        '{K_RD, 8'h14, 40'h0, 40'h0, 4'd9},
        '{K_WR, 8'h34, 40'hFFFFFFFF, 40'h0, 4'd9},
        '{K_RD, 8'h34, 40'h0, 40'h0, 4'd9},
        '{K_WR, 8'h00, 40'h0, 40'h0, 4'd7},                 // R7 mask all bank 0
        '{K_LN, 8'h00, 40'h10, 40'h0, 4'd7},
        '{K_RD, 8'h14, 40'h0, 40'h0, 4'd7},
        '{K_WR, 8'h00, 40'hFFFFFFFF, 40'h0, 4'd7},
        '{K_LN, 8'h00, 40'h10, 40'h0, 4'd7},                // no new change
        '{K_LN, 8'h00, 40'h0, 40'h0, 4'd7},
        '{K_LN, 8'h00, 40'h10, 40'h10, 4'd5},
        '{K_WR, 8'h14, 40'h10, 40'h0, 4'd9},
        '{K_LN, 8'h00, 40'h0, 40'h0, 4'd6},
        '{K_WR, 8'h10, 40'h5, 40'h5, 4'd8},                 // R8
        '{K_RD, 8'h10, 40'h0, 40'h5, 4'd8},
        '{K_RD, 8'h14, 40'h0, 40'h5, 4'd8},
        '{K_WR, 8'h10, 40'h5, 40'h0, 4'd8},                 // no 0->1
        '{K_WR, 8'h14, 40'h1, 40'h0, 4'd9},
        '{K_RD, 8'h10, 40'h0, 40'h4, 4'd9},                 // trigger bit cleared too
        '{K_WR, 8'h10, 40'h5, 40'h1, 4'd8},
        '{K_WR, 8'h10, 40'h0, 40'h0, 4'd8},
        '{K_WR, 8'h10, 40'h4, 40'h0, 4'd8},                 // already pending
        '{K_WR, 8'h14, 40'hFFFFFFFF, 40'h0, 4'd9},
        '{K_WR, 8'h10, 40'h0, 40'h0, 4'd8},
        '{K_WR, 8'h00, 40'h0, 40'h0, 4'd8},
        '{K_WR, 8'h10, 40'h2, 40'h0, 4'd8},                 // masked trigger
        '{K_RD, 8'h14, 40'h0, 40'h0, 4'd8},
        '{K_RD, 8'h10, 40'h0, 40'h2, 4'd8},
        '{K_WR, 8'h00, 40'hFFFFFFFF, 40'h0, 4'd8},
        '{K_WR, 8'h10, 40'h00800000, 40'h0, 4'd12},         // R12 direct trigger
        '{K_RD, 8'h10, 40'h0, 40'h0, 4'd4},
        '{K_WR, 8'h30, 40'hFF, 40'h7800000000, 4'd8},
        '{K_RD, 8'h34, 40'h0, 40'h78, 4'd8},
        '{K_WR, 8'h34, 40'hFF, 40'h0, 4'd9},
        '{K_RD, 8'h30, 40'h0, 40'h0, 4'd9},
        '{K_WR, 8'h18, 40'hFFFFFFFF, 40'h0, 4'd11},         // R11
        '{K_RD, 8'h18, 40'h0, 40'h0, 4'd11},
        '{K_RD, 8'h3C, 40'h0, 40'h0, 4'd11},
        '{K_RD, 8'h40, 40'h0, 40'h0, 4'd11},
        '{K_RD, 8'h01, 40'h0, 40'h0, 4'd11},
        '{K_WR, 8'h02, 40'h0, 40'h0, 4'd11},
        '{K_RD, 8'h00, 40'h0, 40'hFFFFFFFF, 4'd11},
        '{K_WR, 8'h60, 40'h0, 40'h0, 4'd11},
        '{K_RD, 8'h20, 40'h0, 40'hFF, 4'd11}
    };

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [39:0] line_i = '0;
    logic        reg_valid_i = 1'b0;
    logic        reg_write_i = 1'b0;
    logic [7:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [39:0] irq_pulse_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk_i = ~clk_i;

    edge_irq_ctrl dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .line_i      (line_i),
        .reg_valid_i (reg_valid_i),
        .reg_write_i (reg_write_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_pulse_o (irq_pulse_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk_i);
        reg_valid_i = 1'b1; reg_write_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk_i);
        reg_valid_i = 1'b0; reg_write_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk_i);
        reg_valid_i = 1'b1; reg_write_i = 1'b0; reg_addr_i = a;
        @(negedge clk_i);
        reg_valid_i = 1'b0;
        d = reg_rdata_o;
    endtask

    task automatic drive_lines(input logic [39:0] v);
        @(negedge clk_i);
        line_i = v;
        @(negedge clk_i);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk_i);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 pulse after reset", 64'(irq_pulse_o), 64'h0);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].kind)
                K_WR: begin
                    wr(VECS[i].addr, VECS[i].data[31:0]);
                    check($sformatf("R%0d vec %0d pulse", VECS[i].req, i),
                          64'(irq_pulse_o), 64'(VECS[i].exp));
                end
                K_RD: begin
                    rd(VECS[i].addr, r);
                    check($sformatf("R%0d vec %0d rdata", VECS[i].req, i),
                          64'(r), 64'(VECS[i].exp));
                end
                default: begin
                    drive_lines(VECS[i].data);
                    check($sformatf("R%0d vec %0d pulse", VECS[i].req, i),
                          64'(irq_pulse_o), 64'(VECS[i].exp));
                end
            endcase
        end

        // R5: pulse lasts a single cycle
        drive_lines(40'h20);
        check("R5 pulse cycle 1", 64'(irq_pulse_o), 64'h20);
        @(negedge clk_i);
        check("R5 pulse cycle 2", 64'(irq_pulse_o), 64'h0);
        drive_lines(40'h0);
        // R10: edge and clear of the same bit together
        @(negedge clk_i);
        line_i = 40'h20;
        reg_valid_i = 1'b1; reg_write_i = 1'b1; reg_addr_i = 8'h14; reg_wdata_i = 32'h20;
        @(negedge clk_i);
        reg_valid_i = 1'b0; reg_write_i = 1'b0;
        check("R10 pulse", 64'(irq_pulse_o), 64'h20);
        rd(8'h14, r);
        check("R10 pending kept", 64'(r), 64'h20);
        wr(8'h14, 32'h20);
        rd(8'h14, r);
        check("R9 cleared", 64'(r), 64'h0);
        drive_lines(40'h0);

        // R2 latency and R13 hold
        @(negedge clk_i);
        reg_valid_i = 1'b1; reg_write_i = 1'b0; reg_addr_i = 8'h08;
        check("R2 before edge", 64'(reg_rdata_o), 64'h0);
        @(negedge clk_i);
        reg_valid_i = 1'b0;
        check("R2 after edge", 64'(reg_rdata_o), 64'h007DFFFF);
        wr(8'h08, 32'h0);
        repeat (3) @(negedge clk_i);
        check("R13 hold", 64'(reg_rdata_o), 64'h007DFFFF);
        rd(8'h08, r);
        check("R4 rise cleared", 64'(r), 64'h0);
        wr(8'h08, 32'hFFFFFFFF);
        wr(8'h28, 32'hFFFFFFFF);

        // R12: toggling direct lines with all selects written
        drive_lines(40'h87_FF820000);
        check("R12 rise", 64'(irq_pulse_o), 64'h0);
        drive_lines(40'h0);
        check("R12 fall", 64'(irq_pulse_o), 64'h0);
        rd(8'h14, r);
        check("R12 pend bank0", 64'(r), 64'h0);
        rd(8'h34, r);
        check("R12 pend bank1", 64'(r), 64'h0);

        // R1: reset in mid-run
        wr(8'h0C, 32'h1);
        @(negedge clk_i);
        rst_ni = 1'b0;
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
        check("R1 pulse", 64'(irq_pulse_o), 64'h0);
        rd(8'h00, r);
        check("R1 enable bank0", 64'(r), 64'hFF820000);
        rd(8'h20, r);
        check("R1 enable bank1", 64'(r), 64'h87);
        rd(8'h0C, r);
        check("R1 fall bank0", 64'(r), 64'h0);
        rd(8'h28, r);
        check("R1 rise bank1", 64'(r), 64'h0);

        finish_run();
    end

endmodule